// File: doc/BRIEF.md
# Filtered Digital Lock Detector

This block decides whether a phase-locked loop is locked by timing the gap between the edges of the divided reference and the divided feedback. Both signals arrive as single-cycle pulses that are already synchronous to a fast sampling clock. The block does not look at every pair of edges. Each input has its own modulo counter, and only the edge that wraps its counter (every `SAMPLE_EVERY`-th edge) takes part in a comparison. The number of sample-clock ticks between the two wrapping edges is the phase error. Which of the two edges comes first does not matter.

Each measured error gets a verdict using two thresholds. An error below the tight threshold is a pass. An error above the loose threshold is a failure. Anything in between is a marginal result. Lock is declared only after `PASS_RUN` passes in a row, and it is dropped on the first failure. A missing edge is also a failure: if the second wrapping edge does not arrive within `TIMEOUT_TICKS` of the first, the comparison fails, and both counters restart so the next comparison lines up again. The lock output is held low while the enable input is low or while the loop is powered down.

Top module: `pll_lock_filter`

## Requirements
- R1: A comparison uses only the `SAMPLE_EVERY`-th pulse on each input, counted from reset or from the last resynchronisation. Phase errors on all other pulse pairs have no effect on `lock_o`.
- R2: Phase error means the clock-cycle distance between the two wrapping pulses. A result is a pass when this error is strictly less than `TIGHT_TICKS`. `lock_o` rises on the clock edge after the cycle that completes the `PASS_RUN`-th consecutive pass, and not before.
- R3: A phase error strictly greater than `LOOSE_TICKS` clears the lock on the clock edge after the measurement completes.
- R4: An error from `TIGHT_TICKS` to `LOOSE_TICKS` inclusive leaves an asserted lock unchanged. It also restarts the consecutive-pass count from zero.
- R5: The second wrapping pulse may fail to arrive within `TIMEOUT_TICKS` cycles after the first. That comparison is then a failure and clears the lock.
- R6: A timeout resets both pulse counters to zero, so the next comparison is formed by the next `SAMPLE_EVERY` pulses on each input.
- R7: `lock_o` is 0 whenever `ld_en` is 0. The lock and the pass count are kept, so `lock_o` returns as soon as `ld_en` goes back to 1.
- R8: While `pwr_down` is 1, `lock_o` is 0, the pass count and the lock are cleared, and pulses are ignored. After release, a full run of passes is needed again.
- R9: After reset, `lock_o` is 0 and both pulse counters start at zero.
- R10: A feedback pulse that leads the reference by d cycles gets the same verdict as one that lags by d cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_pulse | input | 1 | One-cycle pulse per divided reference edge |
| fb_pulse | input | 1 | One-cycle pulse per divided feedback edge |
| ld_en | input | 1 | Lock indication enable, 1 = output allowed |
| pwr_down | input | 1 | Loop powered down, 1 = clear and hold low |
| lock_o | output | 1 | Filtered lock indication |

## Verification
The bench builds the block with `SAMPLE_EVERY` = 4, `TIGHT_TICKS` = 3, `LOOSE_TICKS` = 6, `PASS_RUN` = 4 and `TIMEOUT_TICKS` = 12, with one pulse pair every 20 clocks. The short sampling interval keeps the consecutive-pass runs, the resynchronisation after a dropped edge and the power-down reacquisition within a few hundred cycles each. The small thresholds let single-tick offsets land exactly on each boundary: 2, 3, 6 and 7 ticks, both leading and lagging. The 12-tick timeout together with the 20-clock period makes a dropped feedback edge time out inside the same reference period.

// File: rtl/pll_lock_filter.sv
module pll_lock_filter #(
  parameter int SAMPLE_EVERY  = 64,
  parameter int TIGHT_TICKS   = 4,
  parameter int LOOSE_TICKS   = 8,
  parameter int PASS_RUN      = 4,
  parameter int TIMEOUT_TICKS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_pulse,
  input  logic fb_pulse,
  input  logic ld_en,
  input  logic pwr_down,
  output logic lock_o
);
  localparam int CW = (SAMPLE_EVERY > 2) ? $clog2(SAMPLE_EVERY) : 1;
  localparam int EW = $clog2(TIMEOUT_TICKS + 1);
  localparam int RW = $clog2(PASS_RUN + 1);
  localparam logic [CW-1:0] LAST_C  = CW'(SAMPLE_EVERY - 1);
  localparam logic [EW-1:0] TIGHT_E = EW'(TIGHT_TICKS);
  localparam logic [EW-1:0] LOOSE_E = EW'(LOOSE_TICKS);
  localparam logic [EW-1:0] TMO_E   = EW'(TIMEOUT_TICKS);
  localparam logic [RW-1:0] RUN_MAX = RW'(PASS_RUN);

  typedef enum logic [1:0] {IDLE, WAIT_FB, WAIT_REF} meas_t;

  meas_t          st_q;
  logic [CW-1:0]  ref_cnt, fb_cnt;
  logic [EW-1:0]  err_q;
  logic [RW-1:0]  run_q;
  logic           ld_q;

  wire ref_wrap = ref_pulse && (ref_cnt == LAST_C);
  wire fb_wrap  = fb_pulse  && (fb_cnt  == LAST_C);

  logic          done, tmo;
  logic [EW-1:0] err;
  always_comb begin
    done = 1'b0;
    tmo  = 1'b0;
    err  = '0;
    case (st_q)
      IDLE:     done = ref_wrap && fb_wrap;
      WAIT_FB:  begin done = fb_wrap;  err = err_q; tmo = !fb_wrap  && (err_q == TMO_E); end
      WAIT_REF: begin done = ref_wrap; err = err_q; tmo = !ref_wrap && (err_q == TMO_E); end
      default:  ;
    endcase
  end

  wire pass = done && (err < TIGHT_E);
  wire bad  = tmo || (done && (err > LOOSE_E));
  wire mid  = done && !pass && !bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || pwr_down) begin
      ref_cnt <= '0;
      fb_cnt  <= '0;
    end else if (tmo) begin
      ref_cnt <= '0;
      fb_cnt  <= '0;
    end else begin
      if (ref_pulse) ref_cnt <= (ref_cnt == LAST_C) ? '0 : ref_cnt + 1'b1;
      if (fb_pulse)  fb_cnt  <= (fb_cnt  == LAST_C) ? '0 : fb_cnt  + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= IDLE;
      err_q <= '0;
    end else if (pwr_down || done || tmo) begin
      st_q  <= IDLE;
      err_q <= '0;
    end else if (st_q == IDLE) begin
      if (ref_wrap)     begin st_q <= WAIT_FB;  err_q <= EW'(1); end
      else if (fb_wrap) begin st_q <= WAIT_REF; err_q <= EW'(1); end
    end else begin
      err_q <= err_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      ld_q  <= 1'b0;
    end else if (pwr_down || bad) begin
      run_q <= '0;
      ld_q  <= 1'b0;
    end else if (mid) begin
      run_q <= '0;
    end else if (pass) begin
      if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
      if (run_q >= RUN_MAX - 1'b1) ld_q <= 1'b1;
    end
  end

  assign lock_o = ld_q && ld_en && !pwr_down;

  // R2
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ld_q) |-> $past(run_q) >= RUN_MAX - 1'b1);
  // R3
  lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (err > LOOSE_E)) |=> !ld_q);
  // R4
  mid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mid && !pwr_down) |=> (ld_q == $past(ld_q)) && (run_q == '0));
  // R6
  resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> (ref_cnt == '0) && (fb_cnt == '0) && (st_q == IDLE));
  // R8
  pd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> !ld_q && (run_q == '0));
  // R1
  verdict_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ld_q) |-> $past(done || tmo || pwr_down));
endmodule

// File: tb/sim_pll_lock_filter.sv
module sim_pll_lock_filter;
  localparam int CLK_PERIOD = 10;
  localparam int N     = 4;
  localparam int TIGHT = 3;
  localparam int LOOSE = 6;
  localparam int RUN   = 4;
  localparam int TMO   = 12;
  localparam int P     = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ref_pulse = 1'b0, fb_pulse = 1'b0, ld_en = 1'b1, pwr_down = 1'b0;
  logic lock_o;
  int checks = 0, failures = 0;
  int run_m = 0;
  bit ld_m = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_lock_filter #(.SAMPLE_EVERY(N), .TIGHT_TICKS(TIGHT), .LOOSE_TICKS(LOOSE),
                    .PASS_RUN(RUN), .TIMEOUT_TICKS(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
    .ld_en(ld_en), .pwr_down(pwr_down), .lock_o(lock_o));

  task automatic chk(input bit got, input bit exp, input string req);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s lock_o=%0b expected=%0b", req, got, exp);
    end
  endtask

  task automatic one_pair(input int lag, input bit drop);
    for (int t = 0; t < P; t++) begin
      @(negedge clk);
      ref_pulse = (t == 5);
      fb_pulse  = !drop && (t == 5 + lag);
    end
  endtask

  task automatic compare(input int lag, input int other_lag, input bit drop, input string req);
    int e;
    for (int k = 0; k < N - 1; k++) one_pair(other_lag, 1'b0);
    one_pair(lag, drop);
    e = (lag < 0) ? -lag : lag;
    if (drop || e > LOOSE) begin ld_m = 0; run_m = 0; end
    else if (e >= TIGHT) run_m = 0;
    else begin
      if (run_m < RUN) run_m++;
      if (run_m >= RUN) ld_m = 1;
    end
    chk(lock_o, ld_m && ld_en && !pwr_down, req);
  endtask

  task automatic t_reset();
    chk(lock_o, 1'b0, "R9");
  endtask

  task automatic t_acquire();
    compare(0, 0, 0, "R2 pass1");
    compare(2, 0, 0, "R2 pass2");
    compare(-2, 0, 0, "R10 pass3");
    chk(lock_o, 1'b0, "R2 not before run");
    compare(1, 0, 0, "R2 pass4");
    chk(lock_o, 1'b1, "R2 locked");
  endtask

  task automatic t_skip();
    compare(0, 11, 0, "R1 off-sample errors ignored");
    compare(-1, -5, 0, "R1 off-sample lead ignored");
    chk(lock_o, 1'b1, "R1 still locked");
  endtask

  task automatic t_mid();
    compare(LOOSE, 0, 0, "R4 at loose keeps");
    compare(-TIGHT, 0, 0, "R4 at tight keeps");
    chk(lock_o, 1'b1, "R4 held");
    compare(LOOSE + 1, 0, 0, "R3 beyond loose");
    chk(lock_o, 1'b0, "R3 dropped");
    compare(0, 0, 0, "R4 p1");
    compare(0, 0, 0, "R4 p2");
    compare(0, 0, 0, "R4 p3");
    compare(TIGHT, 0, 0, "R4 mid resets run");
    compare(0, 0, 0, "R4 p1b");
    compare(0, 0, 0, "R4 p2b");
    compare(0, 0, 0, "R4 p3b");
    chk(lock_o, 1'b0, "R4 run restarted");
    compare(0, 0, 0, "R4 p4b");
    chk(lock_o, 1'b1, "R4 relocked");
    compare(-(LOOSE + 1), 0, 0, "R10 lead beyond loose");
    chk(lock_o, 1'b0, "R10 dropped on lead");
  endtask

  task automatic t_timeout();
    for (int k = 0; k < RUN; k++) compare(0, 0, 0, "R5 prelock");
    chk(lock_o, 1'b1, "R5 locked before drop");
    compare(0, 0, 1, "R5 missing edge");
    chk(lock_o, 1'b0, "R5 timeout fails");
    for (int k = 0; k < RUN; k++) compare(1, 0, 0, "R6 after resync");
    chk(lock_o, 1'b1, "R6 resynced and relocked");
  endtask

  task automatic t_enable();
    @(negedge clk); ld_en = 1'b0;
    @(negedge clk);
    chk(lock_o, 1'b0, "R7 masked");
    compare(0, 0, 0, "R7 masked during compare");
    @(negedge clk); ld_en = 1'b1;
    @(negedge clk);
    chk(lock_o, 1'b1, "R7 state kept");
  endtask

  task automatic t_pwrdn();
    @(negedge clk); pwr_down = 1'b1;
    @(negedge clk);
    chk(lock_o, 1'b0, "R8 forced low");
    one_pair(0, 0);
    @(negedge clk); pwr_down = 1'b0;
    ld_m = 0; run_m = 0;
    for (int k = 0; k < RUN - 1; k++) compare(0, 0, 0, "R8 reacquire");
    chk(lock_o, 1'b0, "R8 full run needed");
    compare(0, 0, 0, "R8 relock");
    chk(lock_o, 1'b1, "R8 relocked");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_acquire();
    t_skip();
    t_mid();
    t_timeout();
    t_enable();
    t_pwrdn();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule